// File: doc/BRIEF.md
# AFSK HDLC Transmit Modulator

This block converts a stream of frame bytes into audio-frequency shift keyed samples. Bytes arrive on a ready/valid input. The block wraps them in HDLC framing: a programmable run of flag bytes before the payload and another run after it. It applies HDLC zero insertion and NRZI line coding. The result is one unsigned 8-bit sine sample per sample tick.

NRZI is produced directly in the tone generator. A data one keeps the current tone. A data zero, or an inserted zero, swaps the phase increment between mark and space. A phase accumulator indexes an internal sine table, so there is no separate bit stream stage.

Upstream software marks bytes that must go out literally by placing an escape code before them. The block starts by itself when the first byte arrives and stops by itself when both the payload and the trailing flags are used up.

Top module: `afsk_tx_mod`

## Requirements
- R1: After reset, `busy` is 0, `sampleOut` is 128 (midscale) and `inReady` is 1.
- R2: The block starts when a byte is waiting while it is idle. At start, `busy` rises, the tone is set to mark, the accumulator phase is cleared to 0, the ones counter is cleared, and `preambleLen` and `tailLen` are latched. The first tick after start therefore produces the sample of phase 0 plus the increment of the first bit's tone.
- R3: Before any payload, the block sends the latched number of flag bytes (0x7E).
- R4: Every bit lasts `SAMPLES_PER_BIT` ticks (8). Bits leave least significant first. A data 1 keeps the current tone; a data 0 swaps between mark and space.
- R5: In a stuffed byte, once 5 consecutive ones have been sent, one extra bit period is inserted before the next data bit. That period swaps the tone, clears the ones count and consumes no data bit. The ones count carries across byte boundaries.
- R6: A flag byte (0x7E) or a reset byte (0x7F) that is not escaped is sent without stuffing. When the byte after such an unstuffed byte is fetched, the ones count is cleared.
- R7: An escape byte (0x1B) is not sent. The byte that follows it is sent in its place, with stuffing enabled, even if it is 0x7E, 0x7F or 0x1B. If no byte is waiting behind the escape when it is fetched, the escape is dropped and transmission stops.
- R8: When the payload is used up, the latched number of flag bytes is sent as a tail. At the next byte boundary with no payload waiting and no tail left, `busy` falls on that tick and `sampleOut` returns to 128.
- R9: On each tick while sending, the phase advances by 64 (mark) or 117 (space), modulo 512. `sampleOut` becomes round(128 + 127·sin(2π·phase/512)) on the same clock edge as the tick.
- R10: Between ticks `sampleOut` does not change. `inReady` is high whenever fewer than two bytes are waiting inside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle strobe per output sample (9600 Hz) |
| preambleLen | input | COUNT_W | Number of leading flag bytes, latched at start |
| tailLen | input | COUNT_W | Number of trailing flag bytes, latched at start |
| inData | input | 8 | Frame byte |
| inValid | input | 1 | `inData` is valid |
| inReady | output | 1 | Block can take a byte this cycle |
| busy | output | 1 | Transmission in progress |
| sampleOut | output | SAMPLE_W | Unsigned sine sample |

## Verification
Any wrong internal state shows up as a wrong sample value within one tick. A wrong tone makes the next phase step wrong on the very next tick. An ones count that is off by one adds or removes a whole bit period of 8 ticks. After that, every later sample carries a phase offset, so one framing slip corrupts the rest of the frame. A bad byte counter or escape decision shows up at the end of the frame, as a `busy` fall that comes early or late compared with the expected sample count.

// File: rtl/afsk_tx_pkg.sv
package afsk_tx_pkg;
  localparam logic [7:0] FLAG_BYTE  = 8'h7E;
  localparam logic [7:0] RESET_BYTE = 8'h7F;
  localparam logic [7:0] ESC_BYTE   = 8'h1B;

  // strobes from the framing control to the tone synthesizer
  typedef struct packed {
    logic clearPhase;  // transmission start: phase to zero
    logic advance;     // tick while sending: step phase, emit sample
    logic park;        // tick on which sending stops: output to midscale
    logic space;       // tone for this tick: 1 = space, 0 = mark
  } toneStrobe_t;
endpackage

// File: rtl/afsk_tx_ctrl.sv
module afsk_tx_ctrl
  import afsk_tx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 8,
  parameter int COUNT_W         = 16,
  parameter int STUFF_LIMIT     = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleTick,
  input  logic [COUNT_W-1:0] preambleLen,
  input  logic [COUNT_W-1:0] tailLen,
  input  logic [7:0]         inData,
  input  logic               inValid,
  output logic               inReady,
  output logic               busy,
  output toneStrobe_t        strb
);
  localparam int IDX_W  = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1;
  localparam int ONES_W = $clog2(STUFF_LIMIT + 9);
  localparam logic [IDX_W-1:0]  IDX_RELOAD = IDX_W'(SAMPLES_PER_BIT - 1);
  localparam logic [ONES_W-1:0] ONES_MAX   = ONES_W'(STUFF_LIMIT);

  logic [IDX_W-1:0]   sampleIdx, idxN;
  logic [7:0]         bitMask, maskN, maskW;
  logic [7:0]         curByte, byteN;
  logic               stuffEn, stuffN;
  logic [ONES_W-1:0]  onesCnt, onesN, onesW;
  logic [COUNT_W-1:0] preLeft, preN, tailLeft, tailN;
  logic               toneSpace, toneN;
  logic               busyN;
  logic [1:0][7:0]    holdData, holdN;
  logic [1:0]         holdCnt, cntN;
  logic [1:0]         popCnt;
  logic               stopNow, litByte, work, haveByte;

  assign haveByte = (holdCnt != 2'd0);
  assign work     = busy && sampleTick;
  assign inReady  = (holdCnt != 2'd2);

  // framing, stuffing and NRZI decision for one tick
  always_comb begin
    busyN = busy; idxN = sampleIdx; maskN = bitMask; byteN = curByte;
    stuffN = stuffEn; onesN = onesCnt; preN = preLeft; tailN = tailLeft;
    toneN = toneSpace; popCnt = 2'd0; stopNow = 1'b0; litByte = 1'b0;
    onesW = onesCnt; maskW = bitMask;
    if (!busy) begin
      if (haveByte) begin
        busyN = 1'b1; toneN = 1'b0; onesN = '0;
        preN = preambleLen; tailN = tailLen; idxN = '0; maskN = '0;
      end
    end else if (work) begin
      if (sampleIdx == '0) begin
        if (bitMask == '0) begin
          if (!haveByte && tailLeft == '0) begin
            stopNow = 1'b1;
          end else begin
            if (!stuffEn) onesW = '0;
            stuffN = 1'b1;
            if (preLeft != '0) begin
              preN = preLeft - 1'b1; byteN = FLAG_BYTE;
            end else if (!haveByte) begin
              tailN = tailLeft - 1'b1; byteN = FLAG_BYTE;
            end else begin
              byteN = holdData[0]; popCnt = 2'd1;
              if (holdData[0] == ESC_BYTE) begin
                if (holdCnt == 2'd2) begin
                  byteN = holdData[1]; popCnt = 2'd2; litByte = 1'b1;
                end else begin
                  stopNow = 1'b1;
                end
              end
            end
            if (!litByte && (byteN == FLAG_BYTE || byteN == RESET_BYTE)) stuffN = 1'b0;
            maskW = 8'h01;
          end
        end
        if (stopNow) begin
          busyN = 1'b0;
        end else begin
          idxN = IDX_RELOAD;
          if (stuffN && onesW >= ONES_MAX) begin
            onesN = '0; toneN = !toneSpace; maskN = maskW;
          end else if (|(byteN & maskW)) begin
            onesN = onesW + 1'b1; maskN = maskW << 1;
          end else begin
            onesN = '0; toneN = !toneSpace; maskN = maskW << 1;
          end
        end
      end else begin
        idxN = sampleIdx - 1'b1;
      end
    end
  end

  // two-byte lookahead so an escape and its follower are seen together
  always_comb begin
    holdN = holdData; cntN = holdCnt;
    if (popCnt == 2'd2) begin
      cntN = 2'd0;
    end else if (popCnt == 2'd1) begin
      holdN[0] = holdData[1]; cntN = holdCnt - 2'd1;
    end
    if (inValid && inReady) begin
      holdN[cntN[0]] = inData; cntN = cntN + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; sampleIdx <= '0; bitMask <= '0; curByte <= '0;
      stuffEn <= 1'b0; onesCnt <= '0; preLeft <= '0; tailLeft <= '0;
      toneSpace <= 1'b0; holdData <= '0; holdCnt <= 2'd0;
    end else begin
      busy <= busyN; sampleIdx <= idxN; bitMask <= maskN; curByte <= byteN;
      stuffEn <= stuffN; onesCnt <= onesN; preLeft <= preN; tailLeft <= tailN;
      toneSpace <= toneN; holdData <= holdN; holdCnt <= cntN;
    end
  end

  always_comb begin
    strb.clearPhase = !busy && haveByte;
    strb.advance    = work && !stopNow;
    strb.park       = work && stopNow;
    strb.space      = toneN;
  end

  // R5: with stuffing on, a run never exceeds the limit
  p_ones_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy && stuffEn |-> onesCnt <= ONES_MAX);
  // R4: one data bit at a time
  p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bitMask));
  // R4: tone only moves at a bit boundary
  p_tone_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy && !(sampleTick && sampleIdx == '0) |=> $stable(toneSpace));
  // R8: sending ends only on a tick
  p_stop_on_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(sampleTick));
  // R10: bit timing frozen between ticks
  p_idx_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && !sampleTick |=> $stable(sampleIdx));
endmodule

// File: rtl/afsk_tx_synth.sv
module afsk_tx_synth
  import afsk_tx_pkg::*;
#(
  parameter int TABLE_BITS = 9,
  parameter int MARK_INC   = 64,
  parameter int SPACE_INC  = 117,
  parameter int SAMPLE_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  toneStrobe_t         strb,
  output logic [SAMPLE_W-1:0] sampleOut
);
  localparam int  TABLE_LEN = 1 << TABLE_BITS;
  localparam int  MID_I     = 1 << (SAMPLE_W - 1);
  localparam real AMP       = real'(MID_I - 1);
  localparam real TWO_PI    = 6.283185307179586;
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(MID_I);

  logic [SAMPLE_W-1:0]   sineRom [TABLE_LEN];
  logic [TABLE_BITS-1:0] phaseAcc, phaseStep, phaseNext;

  for (genvar i = 0; i < TABLE_LEN; i++) begin : g_rom
    localparam int ENTRY = int'(real'(MID_I) + AMP * $sin(TWO_PI * real'(i) / real'(TABLE_LEN)));
    assign sineRom[i] = SAMPLE_W'(ENTRY);
  end

  assign phaseStep = strb.space ? TABLE_BITS'(SPACE_INC) : TABLE_BITS'(MARK_INC);
  assign phaseNext = phaseAcc + phaseStep;  // wraps at table length

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseAcc  <= '0;
      sampleOut <= MID;
    end else if (strb.clearPhase) begin
      phaseAcc <= '0;
    end else if (strb.advance) begin
      phaseAcc  <= phaseNext;
      sampleOut <= sineRom[phaseNext];
    end else if (strb.park) begin
      sampleOut <= MID;
    end
  end

  // R8: output returns to midscale when sending stops
  p_park_mid_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.park |=> sampleOut == MID);
  // R10: output holds without a tick
  p_hold_out_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance && !strb.park |=> $stable(sampleOut));
  // R2: start clears the phase
  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearPhase |=> phaseAcc == '0);
endmodule

// File: rtl/afsk_tx_mod.sv
module afsk_tx_mod
  import afsk_tx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 8,
  parameter int TABLE_BITS      = 9,
  parameter int MARK_INC        = 64,
  parameter int SPACE_INC       = 117,
  parameter int SAMPLE_W        = 8,
  parameter int COUNT_W         = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleTick,
  input  logic [COUNT_W-1:0]  preambleLen,
  input  logic [COUNT_W-1:0]  tailLen,
  input  logic [7:0]          inData,
  input  logic                inValid,
  output logic                inReady,
  output logic                busy,
  output logic [SAMPLE_W-1:0] sampleOut
);
  toneStrobe_t strb;

  afsk_tx_ctrl #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT),
    .COUNT_W(COUNT_W),
    .STUFF_LIMIT(5)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
    .preambleLen(preambleLen), .tailLen(tailLen),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .busy(busy), .strb(strb)
  );

  afsk_tx_synth #(
    .TABLE_BITS(TABLE_BITS),
    .MARK_INC(MARK_INC),
    .SPACE_INC(SPACE_INC),
    .SAMPLE_W(SAMPLE_W)
  ) u_synth (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleOut(sampleOut)
  );
endmodule

// File: tb/sim_afsk_tx_mod.sv
module sim_afsk_tx_mod;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleTick = 1'b0;
  logic [15:0] preambleLen = '0;
  logic [15:0] tailLen = '0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inReady, busy;
  logic [7:0]  sampleOut;

  int checks = 0, fails = 0;
  int expQ[$];
  string tag = "R1";
  bit firstPending = 0, frameDone = 0, busyPrev = 0;
  int lastOut = 128, tickCnt = 0;
  int mTone, mPh;

  always #4 clk = ~clk;  // 125 MHz

  afsk_tx_mod u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
    .preambleLen(preambleLen), .tailLen(tailLen),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .busy(busy), .sampleOut(sampleOut)
  );

  task automatic check(bit ok, string t, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // R9: sample for a phase
  function automatic int sineAt(int p);
    return int'(128.0 + 127.0 * $sin(6.283185307179586 * real'(p) / 512.0));
  endfunction

  // R4: one bit period on the given tone
  task automatic emitBit();
    for (int s = 0; s < 8; s++) begin
      mPh = (mPh + (mTone != 0 ? 117 : 64)) % 512;
      expQ.push_back(sineAt(mPh));
    end
  endtask

  // reference framing: R3 preamble, R5 stuffing, R6 unstuffed flags, R7 escape, R8 tail
  task automatic buildFrame(int pre, int tl, byte unsigned d[$]);
    int ones = 0, idx = 0, preL = pre, tailL = tl;
    bit stuff = 0;
    mTone = 0; mPh = 0;
    forever begin
      byte unsigned b;
      bit haveB, lit;
      haveB = idx < d.size();
      lit = 0;
      if (!haveB && tailL == 0) break;
      if (!stuff) ones = 0;
      stuff = 1;
      if (preL > 0) begin preL--; b = 8'h7E; end
      else if (!haveB) begin tailL--; b = 8'h7E; end
      else begin
        b = d[idx]; idx++;
        if (b == 8'h1B) begin
          if (idx < d.size()) begin b = d[idx]; idx++; lit = 1; end
          else break;
        end
      end
      if (!lit && (b == 8'h7E || b == 8'h7F)) stuff = 0;
      for (int k = 0; k < 8; ) begin
        if (stuff && ones >= 5) begin
          ones = 0; mTone ^= 1; emitBit();
        end else begin
          if (b[k]) ones++;
          else begin ones = 0; mTone ^= 1; end
          emitBit();
          k++;
        end
      end
    end
  endtask

  // tick generator and scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (sampleTick) begin
        if (busyPrev) begin
          if (expQ.size() > 0) begin
            int e;
            e = expQ.pop_front();
            check(sampleOut == e, firstPending ? "R2" : tag, sampleOut, e);
            firstPending = 0;
          end else begin
            // R8: stop on the byte boundary after the last expected sample
            check(busy == 1'b0 && sampleOut == 8'd128, "R8",
                  busy * 1000 + sampleOut, 128);
            frameDone = 1;
          end
        end
      end else begin
        check(sampleOut == lastOut, "R10", sampleOut, lastOut);
      end
      lastOut = sampleOut;
      busyPrev = busy;
      tickCnt = (tickCnt + 1) % 4;
      sampleTick = (tickCnt == 3);
    end
  end

  task automatic runFrame(int pre, int tl, byte unsigned d[$], string t);
    @(negedge clk);
    preambleLen = 16'(pre); tailLen = 16'(tl); tag = t;
    expQ.delete();
    buildFrame(pre, tl, d);
    firstPending = 1; frameDone = 0;
    foreach (d[i]) begin
      bit hs;
      inData = d[i]; inValid = 1'b1;
      forever begin
        hs = inReady;
        @(negedge clk);
        if (hs) break;
      end
    end
    inValid = 1'b0;
    wait (frameDone);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", busy, 0);
    check(sampleOut == 8'd128, "R1", sampleOut, 128);
    check(inReady == 1'b1, "R1", inReady, 1);
    runFrame(2, 1, '{8'h55, 8'hA3}, "R3 R4 R9");
    runFrame(1, 1, '{8'hFF, 8'h1F, 8'h7F, 8'h7E, 8'hF8}, "R5 R6");
    runFrame(0, 2, '{8'h1B, 8'h7E, 8'h1B, 8'h1B, 8'h1B, 8'h7F, 8'hFC}, "R7");
    runFrame(0, 3, '{8'h41, 8'h1B}, "R7 R8");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=frame end");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule